// File: doc/BRIEF.md
# Smooth Pulse-Masking Clock Trim

This block trims the effective rate of a slow timekeeping clock without touching the oscillator. It sits between a raw tick enable (one pulse per nominal 32768 Hz period, carried in a faster system clock) and the prescaler chain. Over a long power-of-two window of input ticks it removes a programmed number of pulses and can also insert one extra pulse at a fixed spacing. The spacing is chosen so that the corrections are spread evenly across the window instead of clustering at one end.

Software supplies a new trim setting through a one-cycle write strobe. The block holds that setting in a staging copy and raises a pending flag. The setting becomes active only when the current window closes, and the flag drops at the same moment. Because of this, every window runs under one consistent setting. The window can be shortened by a factor of two or four. A shorter window gives a coarser mask resolution, so one or two low bits of the mask count are ignored in those modes.

Top module: `smooth_calib`

## Requirements
- R1: After reset `tick_o` and `pending_o` are 0, and the active setting is neutral: mask 0, no plus, full window.
- R2: Every input tick that is not a correction slot appears on `tick_o` exactly one clock cycle later, and no output pulse appears without a cause.
- R3: In a full window of 2^WIN_LOG2 input ticks, exactly `mask` input ticks are removed. `mask` is the 9-bit `cfg_mask_i` value.
- R4: Correction slots are the input ticks whose window position has its low WIN_LOG2-9 bits at zero. A slot whose upper-9-bit index, read bit-reversed, is below the mask loses its tick. As a result, the first half of a full window removes exactly ceil(mask/2) ticks.
- R5: With `cfg_plus_i`=1, every slot adds one pulse, driven on `tick_o` in the cycle after the slot tick's own output cycle (the input must be idle then). If that slot is also masked, the tick passes unchanged and nothing is added.
- R6: `cfg_win_sel_i` encoding: 2'b00 gives a 2^WIN_LOG2-tick window, 2'b01 gives half of that, and 2'b1x gives a quarter (bit 1 takes priority).
- R7: In the half window, bit 0 of the mask is treated as 0. In the quarter window, bits 1:0 are treated as 0.
- R8: A write raises `pending_o` one cycle later. The flag stays high until the last tick of the window that is running, and drops in the cycle after that tick. Among several writes before the boundary, the last one wins.
- R9: A written setting has no effect on the window that is in progress. It takes effect from the first tick of the next window.
- R10: Each window's output pulse count equals its length plus (slots × plus) minus the effective masked count. For a full window this is length + 512·plus − mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Raw slow-clock tick enable |
| cfg_we_i | input | 1 | Write strobe for a new trim setting |
| cfg_mask_i | input | MASK_W | Number of ticks to remove per full window |
| cfg_plus_i | input | 1 | Insert one pulse per slot |
| cfg_win_sel_i | input | 2 | Window length select |
| tick_o | output | 1 | Trimmed tick enable, one cycle latency |
| pending_o | output | 1 | New setting waiting for window boundary |

## Verification
A window counter that has drifted or wrapped at the wrong length changes the per-window pulse count. It also moves the cycle at which `pending_o` falls, so the error shows up at the first boundary after a write. A wrong bit reversal or compare keeps the whole-window count unchanged but unbalances the halves. For that reason the first-half count is checked separately. An inserted pulse that collides with an input tick, or a setting applied too early, shows up within one window as a pulse-count mismatch.

// File: rtl/smooth_calib_pkg.sv
package smooth_calib_pkg;

  typedef enum logic [1:0] {
    WIN_FULL  = 2'b00,
    WIN_HALF  = 2'b01,
    WIN_QTR   = 2'b10,
    WIN_QTR_B = 2'b11
  } win_sel_e;

  // log2 of the window shortening factor
  function automatic logic [1:0] win_shift(input logic [1:0] sel);
    case (win_sel_e'(sel))
      WIN_FULL: return 2'd0;
      WIN_HALF: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/calib_cfg.sv
module calib_cfg
  import smooth_calib_pkg::*;
#(
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              plus_i,
  input  logic [1:0]        sel_i,
  input  logic              win_end_i,
  output logic [MASK_W-1:0] act_mask_o,
  output logic              act_plus_o,
  output logic [1:0]        act_shift_o,
  output logic              pending_o
);

  logic [MASK_W-1:0] stg_mask_q, act_mask_q;
  logic              stg_plus_q, act_plus_q;
  logic [1:0]        stg_shift_q, act_shift_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_mask_q  <= '0;
      stg_plus_q  <= 1'b0;
      stg_shift_q <= 2'd0;
      act_mask_q  <= '0;
      act_plus_q  <= 1'b0;
      act_shift_q <= 2'd0;
      pend_q      <= 1'b0;
    end else if (we_i) begin
      stg_mask_q  <= mask_i;
      stg_plus_q  <= plus_i;
      stg_shift_q <= win_shift(sel_i);
      pend_q      <= 1'b1;
    end else if (win_end_i && pend_q) begin
      act_mask_q  <= stg_mask_q;
      act_plus_q  <= stg_plus_q;
      act_shift_q <= stg_shift_q;
      pend_q      <= 1'b0;
    end
  end

  // shorter windows lose mask resolution
  always_comb begin
    case (act_shift_q)
      2'd0:    act_mask_o = act_mask_q;
      2'd1:    act_mask_o = {act_mask_q[MASK_W-1:1], 1'b0};
      default: act_mask_o = {act_mask_q[MASK_W-1:2], 2'b00};
    endcase
  end

  assign act_plus_o  = act_plus_q;
  assign act_shift_o = act_shift_q;
  assign pending_o   = pend_q;

  AST_PEND_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(we_i)); // R8
  AST_APPLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({act_mask_q, act_plus_q, act_shift_q}) |-> $past(win_end_i)); // R9
  AST_MASK_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_shift_o != 2'd0) |-> (act_mask_o[0] == 1'b0)); // R7

endmodule

// File: rtl/calib_win_cnt.sv
module calib_win_cnt #(
  parameter int WIN_LOG2 = 20,
  parameter int MASK_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        shift_i,
  output logic              win_end_o,
  output logic              slot_hit_o,
  output logic [MASK_W-1:0] slot_o
);

  localparam int SLOT_LSB = WIN_LOG2 - MASK_W;

  logic [WIN_LOG2-1:0] cnt_q;
  logic [WIN_LOG2-1:0] last;

  assign last       = {WIN_LOG2{1'b1}} >> shift_i;
  assign win_end_o  = tick_i && (cnt_q == last);
  assign slot_hit_o = tick_i && (cnt_q[SLOT_LSB-1:0] == '0);
  assign slot_o     = cnt_q[WIN_LOG2-1:SLOT_LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last); // R6
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/calib_pulse.sv
module calib_pulse #(
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              slot_hit_i,
  input  logic [MASK_W-1:0] slot_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              plus_i,
  output logic              tick_o
);

  logic [MASK_W-1:0] rev;
  logic              masked, drop, ins_q, tick_q;

  for (genvar g = 0; g < MASK_W; g++) begin : g_rev
    assign rev[g] = slot_i[MASK_W-1-g];
  end

  assign masked = slot_hit_i && (rev < mask_i);
  assign drop   = masked && !plus_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (tick_i && !drop) || (ins_q && !tick_i);
      if (slot_hit_i && plus_i && !masked) ins_q <= 1'b1;
      else if (!tick_i)                    ins_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  AST_INS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_q && !tick_i) |=> tick_o); // R5
  AST_PASS_NONSLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !slot_hit_i) |=> tick_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ins_q) |=> !tick_o); // R2

endmodule

// File: rtl/smooth_calib.sv
module smooth_calib
  import smooth_calib_pkg::*;
#(
  parameter int WIN_LOG2 = 20,
  parameter int MASK_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cfg_we_i,
  input  logic [MASK_W-1:0] cfg_mask_i,
  input  logic              cfg_plus_i,
  input  logic [1:0]        cfg_win_sel_i,
  output logic              tick_o,
  output logic              pending_o
);

  logic [MASK_W-1:0] act_mask, slot;
  logic              act_plus, win_end, slot_hit;
  logic [1:0]        act_shift;

  calib_cfg #(.MASK_W(MASK_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .mask_i      (cfg_mask_i),
    .plus_i      (cfg_plus_i),
    .sel_i       (cfg_win_sel_i),
    .win_end_i   (win_end),
    .act_mask_o  (act_mask),
    .act_plus_o  (act_plus),
    .act_shift_o (act_shift),
    .pending_o   (pending_o)
  );

  calib_win_cnt #(.WIN_LOG2(WIN_LOG2), .MASK_W(MASK_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .shift_i    (act_shift),
    .win_end_o  (win_end),
    .slot_hit_o (slot_hit),
    .slot_o     (slot)
  );

  calib_pulse #(.MASK_W(MASK_W)) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .slot_hit_i (slot_hit),
    .slot_i     (slot),
    .mask_i     (act_mask),
    .plus_i     (act_plus),
    .tick_o     (tick_o)
  );

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !win_end) |=> pending_o); // R8

endmodule

// File: tb/smooth_calib_tb.sv
module smooth_calib_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_LOG2   = 12;
  localparam int MASK_W     = 9;
  localparam int FULL       = 1 << WIN_LOG2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [MASK_W-1:0] cfg_mask_i = '0;
  logic              cfg_plus_i = 1'b0;
  logic [1:0]        cfg_win_sel_i = 2'b00;
  logic              tick_o, pending_o;

  int n_chk = 0;
  int n_fail = 0;
  int cur_len = FULL;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smooth_calib #(.WIN_LOG2(WIN_LOG2), .MASK_W(MASK_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
    .cfg_mask_i(cfg_mask_i), .cfg_plus_i(cfg_plus_i),
    .cfg_win_sel_i(cfg_win_sel_i), .tick_o(tick_o), .pending_o(pending_o)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); c += int'(tick_o); tick_i = 1'b1;
      @(negedge clk); c += int'(tick_o); tick_i = 1'b0;
    end
  endtask

  task automatic write_cfg(input int mask, input bit plus, input bit [1:0] sel);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_mask_i = MASK_W'(mask); cfg_plus_i = plus; cfg_win_sel_i = sel;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // write mid-window, walk to boundary, then measure one window of new_len
  task automatic apply_and_measure(input int mask, input bit plus, input bit [1:0] sel,
                                   input int new_len, input int exp_total,
                                   input int exp_half, input int exp_old, input bit dbl);
    int a, b, c, h1, h2;
    run_ticks(100, a);
    if (dbl) write_cfg(100, 1'b1, 2'b00);
    write_cfg(mask, plus, sel);
    check_eq("R8 pending after write", int'(pending_o), 1);
    run_ticks(cur_len - 101, b);
    check_eq("R8 pending held before boundary", int'(pending_o), 1);
    run_ticks(1, c);
    check_eq("R8 pending cleared at boundary", int'(pending_o), 0);
    if (exp_old >= 0) check_eq("R9 old window unaffected by write", a + b + c, exp_old);
    cur_len = new_len;
    run_ticks(new_len / 2, h1);
    run_ticks(new_len - new_len / 2, h2);
    if (exp_half >= 0) check_eq("R4 first-half spread", h1, exp_half);
    check_eq("R10 window pulse count", h1 + h2, exp_total);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check_eq("R1 tick_o in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_eq("R1 pending after reset", int'(pending_o), 0);
    // latency: tick at slot 0, neutral setting
    tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    check_eq("R2 one-cycle latency", int'(tick_o), 1);
    @(negedge clk);
    check_eq("R2 single pulse", int'(tick_o), 0);
    run_ticks(FULL - 1, c);
    check_eq("R1 neutral window passes all", c + 1, FULL);
    // R3 full mask, R9 old window unity
    apply_and_measure(511, 1'b0, 2'b00, FULL, FULL - 511, -1, FULL, 1'b0);
    // R5 plus only
    apply_and_measure(0, 1'b1, 2'b00, FULL, FULL + 512, FULL / 2 + 256, -1, 1'b0);
    // R5 cancel overlap, R4 spread: half gets 150 of 300
    apply_and_measure(300, 1'b1, 2'b00, FULL, FULL + 512 - 300, FULL / 2 + 256 - 150, -1, 1'b0);
    // R6 half window, R7 bit0 dropped (301 -> 300, 150 in half window)
    apply_and_measure(301, 1'b0, 2'b01, FULL / 2, FULL / 2 - 150, -1, -1, 1'b0);
    // R6 quarter window via 2'b11, R7 bits1:0 dropped (303 -> 300, 75)
    apply_and_measure(303, 1'b1, 2'b11, FULL / 4, FULL / 4 + 128 - 75, -1, -1, 1'b0);
    // R8 last write wins
    apply_and_measure(40, 1'b0, 2'b00, FULL, FULL - 40, FULL / 2 - 20, -1, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule